// File: doc/BRIEF.md
# Byte-Lane Memory Access Controller

This block sits between a CPU and a 16-bit memory that is organised in words but addressed in bytes. From the lowest address bit, a read strobe, a write strobe and a word/byte select bit, it works out which byte lanes of the memory take part in the access. It drives two active-low byte enables, one for the upper lane and one for the lower lane. It also steers the raw memory read data onto the CPU data bus, so that a byte fetched from the upper half of a word arrives on the lower lanes.

The block keeps the logic small by leaving some work to software. A read of the lower byte returns the whole word unchanged, so the upper bits are not cleared. A byte write only gates the lanes. Software must place the byte in both halves of the written word, because the enable selects whichever half lands in memory. The memory array is outside this block. The enables and the delivered data are registered on one clock edge, so every result appears one cycle after its inputs are sampled.

Top module: `byte_lane_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `ube_n`=1, `lbe_n`=1 and `cpu_rdata`=0.
- R2: All outputs appear one clock cycle after their inputs are sampled. When neither `rd_en` nor `wr_en` is 1, both `ube_n` and `lbe_n` are 1.
- R3: A read (`rd_en`=1) with `addr_lsb`=0 drives `ube_n`=0 and `lbe_n`=0 and delivers `mem_rdata` unchanged on `cpu_rdata`. This holds for word and byte reads alike, so a byte read does not clear bits 15..8.
- R4: A read with `addr_lsb`=1 drives `lbe_n`=1 and `ube_n`=0. It delivers `mem_rdata[15:8]` on `cpu_rdata[7:0]`, and `cpu_rdata[15:8]` also equals `mem_rdata[15:8]`.
- R5: On reads, `word_sel` has no effect. For the same `addr_lsb`, a read gives identical enables and data with `word_sel`=0 and with `word_sel`=1.
- R6: A word write (`wr_en`=1, `rd_en`=0, `word_sel`=1) drives `ube_n`=0 and `lbe_n`=0, whatever the value of `addr_lsb`.
- R7: A byte write (`word_sel`=0) with `addr_lsb`=0 drives `ube_n`=1 and `lbe_n`=0, so only the lower lane is written.
- R8: A byte write with `addr_lsb`=1 drives `ube_n`=0 and `lbe_n`=1, so only the upper lane is written.
- R9: When `rd_en` and `wr_en` are both 1, the access is treated as a read.
- R10: Whenever the cycle is not a read with `addr_lsb`=1, `cpu_rdata` equals `mem_rdata`. This includes writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_lsb | input | 1 | Byte address bit: 0 selects the lower lane, 1 selects the upper lane |
| rd_en | input | 1 | Read strobe, active high |
| wr_en | input | 1 | Write strobe, active high |
| word_sel | input | 1 | 1 = word access, 0 = byte access |
| mem_rdata | input | 16 | Raw data read from the memory |
| ube_n | output | 1 | Upper byte enable, active low, registered |
| lbe_n | output | 1 | Lower byte enable, active low, registered |
| cpu_rdata | output | 16 | Steered data to the CPU, registered |

## Verification
On every cycle, the checker relates the registered enables and delivered data to the inputs sampled one edge earlier. It covers the idle, read, word-write and byte-write lane patterns, the lane swap on an upper-byte read and the pass-through in all other cases. Some behaviours need a comparison across scenarios, which only the bench's stimulus shows. These are that `word_sel` leaves reads unchanged, that a simultaneous read and write resolves as a read, and that a full data sweep produces no cross-lane corruption.

// File: rtl/byte_lane_pkg.sv
// Package: shared types and helpers for the byte-lane controller.
// Assumes a data word made of exactly two equal byte lanes.
package byte_lane_pkg;

    // Kind of access requested in the current cycle
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    // Active-low pair of lane enables
    typedef struct packed {
        logic upper_n;
        logic lower_n;
    } lane_en_t;

    // A read strobe wins over a write strobe
    function automatic acc_kind_t classify(input logic rd, input logic wr);
        if (rd)
            return ACC_READ;
        else if (wr)
            return ACC_WRITE;
        else
            return ACC_IDLE;
    endfunction

endpackage

// File: rtl/byte_lane_decode.sv
// Module: byte_lane_decode
// Turns the access kind, the lane address bit and the word/byte select
// into the active-low lane enables. The result is combinational.
// Assumes: reads ignore the word/byte select, and only writes use it.
module byte_lane_decode
    import byte_lane_pkg::*;
(
    input  acc_kind_t kind,
    input  logic      upper_sel,
    input  logic      word_sel,
    output lane_en_t  lanes
);

    // Pick the lane enables for each access kind
    always_comb begin
        lanes = '{upper_n: 1'b1, lower_n: 1'b1};
        unique case (kind)
            ACC_READ: begin
                lanes.upper_n = 1'b0;
                lanes.lower_n = upper_sel;
            end
            ACC_WRITE: begin
                if (word_sel) begin
                    lanes.upper_n = 1'b0;
                    lanes.lower_n = 1'b0;
                end else begin
                    lanes.upper_n = ~upper_sel;
                    lanes.lower_n = upper_sel;
                end
            end
            default: begin
                lanes.upper_n = 1'b1;
                lanes.lower_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/byte_lane_steer.sv
// Module: byte_lane_steer
// Routes the raw memory data onto the CPU lanes. When swap is high, the
// lowest lane takes the top lane's byte. Every other lane always passes
// its own byte straight through. The result is combinational.
// Assumes: DATA_W is an exact multiple of LANE_W.
module byte_lane_steer #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              swap,
    output logic [DATA_W-1:0] steered
);

    localparam int NUM_LANES = DATA_W / LANE_W;
    localparam int TOP_LO    = (NUM_LANES - 1) * LANE_W;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            // Lowest lane: its own byte, or the top byte on a swap
            assign steered[LANE_W-1:0] =
                swap ? raw[TOP_LO +: LANE_W] : raw[LANE_W-1:0];
        end else begin : g_pass
            // Other lanes: straight pass-through
            assign steered[g*LANE_W +: LANE_W] = raw[g*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/byte_lane_ctrl.sv
// Module: byte_lane_ctrl (top)
// Byte-lane access controller for a word-organised memory. It decodes the
// lane enables and steers read data, then registers both for one cycle.
// Assumes: software duplicates a write byte in both halves of the word,
// and a lower-byte read returns the whole word.
module byte_lane_ctrl
    import byte_lane_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_lsb,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              word_sel,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ube_n,
    output logic              lbe_n,
    output logic [DATA_W-1:0] cpu_rdata
);

    localparam int LANE_W = DATA_W / 2;

    acc_kind_t         kind;
    lane_en_t          lanes;
    logic              swap;
    logic [DATA_W-1:0] steered;

    // Classify the request; a read has priority over a write
    always_comb kind = classify(rd_en, wr_en);

    // The lane swap happens only on an upper-byte read
    always_comb swap = (kind == ACC_READ) && addr_lsb;

    byte_lane_decode u_decode (
        .kind      (kind),
        .upper_sel (addr_lsb),
        .word_sel  (word_sel),
        .lanes     (lanes)
    );

    byte_lane_steer #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_steer (
        .raw     (mem_rdata),
        .swap    (swap),
        .steered (steered)
    );

    // Output register; synchronous reset leaves both lanes disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ube_n     <= 1'b1;
            lbe_n     <= 1'b1;
            cpu_rdata <= '0;
        end else begin
            ube_n     <= lanes.upper_n;
            lbe_n     <= lanes.lower_n;
            cpu_rdata <= steered;
        end
    end

endmodule

// File: rtl/byte_lane_ctrl_chk.sv
// Module: byte_lane_ctrl_chk
// Checker bound to byte_lane_ctrl. Each property relates the registered
// outputs to the inputs sampled one edge earlier.
module byte_lane_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_lsb,
    input logic              rd_en,
    input logic              wr_en,
    input logic              word_sel,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              ube_n,
    input logic              lbe_n,
    input logic [DATA_W-1:0] cpu_rdata
);

    localparam int LANE_W = DATA_W / 2;

    // R1: a reset edge leaves both lanes off and the data at zero
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (ube_n && lbe_n && cpu_rdata == '0));

    // R2: with no strobe, both lanes are off on the next cycle
    assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !wr_en) |=> (ube_n && lbe_n));

    // R3: a lower-lane read enables both lanes and passes the word
    assert_low_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !addr_lsb) |=> (!ube_n && !lbe_n && cpu_rdata == $past(mem_rdata)));

    // R4: an upper-lane read turns the lower lane off and copies the top byte down
    assert_high_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr_lsb) |=> (!ube_n && lbe_n
            && cpu_rdata[LANE_W-1:0] == $past(mem_rdata[DATA_W-1:LANE_W])
            && cpu_rdata[DATA_W-1:LANE_W] == $past(mem_rdata[DATA_W-1:LANE_W])));

    // R6: a word write enables both lanes
    assert_word_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && wr_en && word_sel) |=> (!ube_n && !lbe_n));

    // R7: a byte write to the lower lane turns the upper lane off
    assert_byte_write_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && wr_en && !word_sel && !addr_lsb) |=> (ube_n && !lbe_n));

    // R8: a byte write to the upper lane turns the lower lane off
    assert_byte_write_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && wr_en && !word_sel && addr_lsb) |=> (!ube_n && lbe_n));

    // R10: outside an upper-lane read, the data passes through unchanged
    assert_pass_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr_lsb) |=> (cpu_rdata == $past(mem_rdata)));

endmodule

bind byte_lane_ctrl byte_lane_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_lsb  (addr_lsb),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .word_sel  (word_sel),
    .mem_rdata (mem_rdata),
    .ube_n     (ube_n),
    .lbe_n     (lbe_n),
    .cpu_rdata (cpu_rdata)
);

// File: tb/byte_lane_ctrl_test.sv
// Bench: scoreboard for byte_lane_ctrl. The driver sets the inputs at a
// falling edge and queues the expected result. The monitor pops and
// compares 2 ns after the following rising edge.
module byte_lane_ctrl_test;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_lsb = 1'b0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic          word_sel = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic          ube_n;
    logic          lbe_n;
    logic [DW-1:0] cpu_rdata;

    typedef struct {
        logic          ube_n;
        logic          lbe_n;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // 125 MHz clock: 8 ns period
    always #4 clk = ~clk;

    byte_lane_ctrl #(.DATA_W(DW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_lsb  (addr_lsb),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .word_sel  (word_sel),
        .mem_rdata (mem_rdata),
        .ube_n     (ube_n),
        .lbe_n     (lbe_n),
        .cpu_rdata (cpu_rdata)
    );

    // Independent model of the lane rules taken from the requirements
    function automatic exp_t model(input logic a, input logic rd, input logic wr,
                                   input logic w, input logic [DW-1:0] m, input string r);
        exp_t e;
        e.req = r;
        e.data = m;
        if (rd) begin
            e.ube_n = 1'b0;
            e.lbe_n = a;
            if (a) e.data = {m[15:8], m[15:8]};
        end else if (wr) begin
            e.ube_n = w ? 1'b0 : ~a;
            e.lbe_n = w ? 1'b0 : a;
        end else begin
            e.ube_n = 1'b1;
            e.lbe_n = 1'b1;
        end
        return e;
    endfunction

    // Driver: apply one access and queue the expected result
    task automatic drive(input logic a, input logic rd, input logic wr,
                         input logic w, input logic [DW-1:0] m, input string r);
        @(negedge clk);
        addr_lsb  = a;
        rd_en     = rd;
        wr_en     = wr;
        word_sel  = w;
        mem_rdata = m;
        exp_q.push_back(model(a, rd, wr, w, m, r));
    endtask

    // Monitor: compare the outputs after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_checks++;
            if (ube_n !== e.ube_n || lbe_n !== e.lbe_n || cpu_rdata !== e.data) begin
                n_fail++;
                $display("FAIL %s: got ube_n=%b lbe_n=%b data=%h, expected ube_n=%b lbe_n=%b data=%h",
                         e.req, ube_n, lbe_n, cpu_rdata, e.ube_n, e.lbe_n, e.data);
            end
        end
    end

    // Stimulus
    initial begin
        // R1: reset, checked with mem_rdata nonzero and a read requested
        rd_en = 1'b1;
        mem_rdata = 16'hBEEF;
        repeat (3) @(posedge clk);
        #2;
        n_checks++;
        if (ube_n !== 1'b1 || lbe_n !== 1'b1 || cpu_rdata !== 16'h0000) begin
            n_fail++;
            $display("FAIL R1: got ube_n=%b lbe_n=%b data=%h, expected 1 1 0000",
                     ube_n, lbe_n, cpu_rdata);
        end
        @(negedge clk);
        rst_n = 1'b1;
        rd_en = 1'b0;

        drive(1'b0, 1'b0, 1'b0, 1'b0, 16'h1234, "R2");   // idle
        drive(1'b1, 1'b0, 1'b0, 1'b1, 16'hA5C3, "R2");   // idle, A0 high
        drive(1'b0, 1'b1, 1'b0, 1'b1, 16'hCAFE, "R3");   // word read
        drive(1'b0, 1'b1, 1'b0, 1'b0, 16'hCAFE, "R3");   // byte read, low: upper bits kept
        drive(1'b1, 1'b1, 1'b0, 1'b0, 16'hCAFE, "R4");   // byte read, high
        drive(1'b1, 1'b1, 1'b0, 1'b0, 16'h00FF, "R4");   // upper byte zero
        drive(1'b1, 1'b1, 1'b0, 1'b1, 16'hCAFE, "R5");   // word_sel=1, A0 high
        drive(1'b0, 1'b1, 1'b0, 1'b0, 16'h8001, "R5");
        drive(1'b0, 1'b1, 1'b0, 1'b1, 16'h8001, "R5");
        drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h5555, "R6");   // word write
        drive(1'b1, 1'b0, 1'b1, 1'b1, 16'h5555, "R6");   // word write, A0 high
        drive(1'b0, 1'b0, 1'b1, 1'b0, 16'h7777, "R7");   // byte write, low
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h7777, "R8");   // byte write, high
        drive(1'b1, 1'b1, 1'b1, 1'b0, 16'h9A3C, "R9");   // both strobes: read
        drive(1'b0, 1'b1, 1'b1, 1'b0, 16'h9A3C, "R9");
        drive(1'b1, 1'b0, 1'b1, 1'b0, 16'h3C9A, "R10");  // data passes on a write
        drive(1'b1, 1'b0, 1'b0, 1'b0, 16'hF00D, "R10");  // data passes when idle

        // Sweep: every control combination across walking data
        for (int i = 0; i < 64; i++) begin
            logic [DW-1:0] d;
            d = 16'h0001 << (i % 16);
            d = d ^ (16'h0100 << ((i / 4) % 8));
            drive(i[0], i[1], i[2], i[3], d, "R10");
        end

        // Reset again partway through the run: R1
        drive(1'b1, 1'b1, 1'b0, 1'b0, 16'hABCD, "R4");
        @(negedge clk);
        rst_n = 1'b0;
        rd_en = 1'b1;
        @(posedge clk);
        #3;
        n_checks++;
        if (ube_n !== 1'b1 || lbe_n !== 1'b1 || cpu_rdata !== 16'h0000) begin
            n_fail++;
            $display("FAIL R1: got ube_n=%b lbe_n=%b data=%h, expected 1 1 0000",
                     ube_n, lbe_n, cpu_rdata);
        end
        repeat (2) @(negedge clk);
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected end of stimulus");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule